// File: doc/BRIEF.md
# Configurable AND-OR Logic Array

This block models a field-configurable two-level logic array. There are 8 dedicated inputs and 10 bidirectional pins. Each bidirectional pin is split into a pad-level input `io_i`, a data output `io_o` and an output enable `io_oe_o`. The surrounding pad ring drives the pad from `io_o` while `io_oe_o` is high. In every case it returns the pad level on `io_i`, which feeds back into the array. The array has 42 product terms. 32 of them are logic terms. Any logic term may feed any of the 10 OR gates. Each OR result passes through a per-output polarity stage. The other 10 terms each control the direction of one pin. Evaluation from `in_i`/`io_i` to `io_o`/`io_oe_o` is purely combinational.

The configuration is written serially into a shadow register and made active by a load strobe. A capture command copies the active configuration back into the shadow register so it can be shifted out on `cfg_sdo_o`. A lock command sets a security bit that silences readback. Only an erase command clears that bit, and erase also clears the whole configuration.

Top module: `pla_array`

## Requirements
- R1: The array sees 18 signals: `in_i[s]` is signal s for s in 0..7, and `io_i[k]` is signal 8+k. Signal s gives literal 2s (true) and literal 2s+1 (complement). Configuration bit t*36+l set means literal l joins product term t, and the term is the AND of its joined literals.
- R2: A product term with no literal joined is 1. A term that joins both literals of the same signal is always 0.
- R3: Configuration bit 1512+t*10+o (t in 0..31) connects logic term t to OR gate o. One term may feed several gates, and a gate may sum all 32 terms. A gate with no term connected gives 0.
- R4: Configuration bit 1832+o set inverts OR gate o onto `io_o[o]`. Clear passes the OR result unchanged.
- R5: `io_oe_o[o]` equals product term 32+o.
- R6: While `cfg_shift_i` is high, each clock shifts `cfg_sdi_i` into the top of the 1842-bit shadow register. The first bit shifted in ends up at index 0 after 1842 shifts. The active configuration changes only on a `cfg_load_i` clock, which copies the shadow into it, or on erase.
- R7: On a `cfg_capture_i` clock the active configuration is copied into the shadow register, and capture takes priority over shift. When security is clear, `cfg_sdo_o` shows shadow bit 0. Each following shift then presents the next bit, so a capture followed by shifting reads the configuration back from index 0 upward.
- R8: A `cfg_lock_i` clock sets security. Security then stays set until an erase. While it is set, `cfg_sdo_o` is 0, capture is ignored and the active configuration keeps working.
- R9: A `cfg_erase_i` clock clears the active configuration, the shadow register and security. It overrides a load in the same cycle.
- R10: After reset the configuration is all zero and security is clear. `io_o` is then 0, `io_oe_o` is all ones and `cfg_sdo_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_i | input | 8 | Dedicated logic inputs |
| io_i | input | 10 | Pad level of the bidirectional pins (feedback) |
| io_o | output | 10 | Data driven toward the bidirectional pads |
| io_oe_o | output | 10 | Output enable per bidirectional pad |
| cfg_sdi_i | input | 1 | Serial configuration data in |
| cfg_shift_i | input | 1 | Shift the shadow register by one bit |
| cfg_load_i | input | 1 | Copy shadow into the active configuration |
| cfg_capture_i | input | 1 | Copy active configuration into shadow for readback |
| cfg_lock_i | input | 1 | Set the security bit |
| cfg_erase_i | input | 1 | Clear configuration and security |
| cfg_sdo_o | output | 1 | Serial readback data out |

## Verification
The hardest situations to reach are a product term that is true while several others feed the same OR gate, and an OR gate that sums all 32 terms. Uniform random masks make nearly every term contradictory or false, so those cases almost never occur. The random configurations therefore join each literal with low probability, which keeps a useful share of terms live. A directed configuration wires all 32 terms into one gate, with 31 of them forced false by contradiction, so the output follows a single pin. Security and erase are reached through command sequences. A readback after lock must return zeros, and a readback after erase and reload must return the new vector exactly.

// File: rtl/pla_pkg.sv
`timescale 1ns/1ps
package pla_pkg;
  localparam int unsigned DEF_N_IN = 8;
  localparam int unsigned DEF_N_IO = 10;
  localparam int unsigned DEF_N_LT = 32;
endpackage

// File: rtl/pla_cfg_store.sv
`timescale 1ns/1ps
module pla_cfg_store #(
  parameter int unsigned CFG_W = 1842
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sdi_i,
  input  logic             shift_i,
  input  logic             load_i,
  input  logic             capture_i,
  input  logic             lock_i,
  input  logic             erase_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             secure_o,
  output logic             sdo_o
);
  logic [CFG_W-1:0] shadow_q, active_q;
  logic             secure_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
      secure_q <= 1'b0;
    end else if (erase_i) begin
      shadow_q <= '0;
      active_q <= '0;
      secure_q <= 1'b0;
    end else begin
      if (load_i) active_q <= shadow_q;
      if (lock_i) secure_q <= 1'b1;
      if (capture_i) begin
        if (!secure_q) shadow_q <= active_q;
      end else if (shift_i) begin
        shadow_q <= {sdi_i, shadow_q[CFG_W-1:1]};
      end
    end
  end

  assign cfg_o    = active_q;
  assign secure_o = secure_q;
  assign sdo_o    = secure_q ? 1'b0 : shadow_q[0];
endmodule

// File: rtl/pla_and_plane.sv
`timescale 1ns/1ps
module pla_and_plane #(
  parameter int unsigned N_SIG = 18,
  parameter int unsigned N_PT  = 42,
  localparam int unsigned N_LIT = 2 * N_SIG
) (
  input  logic [N_SIG-1:0]      sig_i,
  input  logic [N_PT*N_LIT-1:0] mask_i,
  output logic [N_PT-1:0]       term_o
);
  logic [N_LIT-1:0] lit;

  always_comb begin
    for (int s = 0; s < int'(N_SIG); s++) begin
      lit[2*s]   = sig_i[s];
      lit[2*s+1] = ~sig_i[s];
    end
  end

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    logic [N_LIT-1:0] sel;
    assign sel       = mask_i[t*N_LIT +: N_LIT];
    assign term_o[t] = &(~sel | lit);
  end
endmodule

// File: rtl/pla_or_plane.sv
`timescale 1ns/1ps
module pla_or_plane #(
  parameter int unsigned N_LT = 32,
  parameter int unsigned N_IO = 10
) (
  input  logic [N_LT-1:0]      term_i,
  input  logic [N_LT*N_IO-1:0] conn_i,
  input  logic [N_IO-1:0]      inv_i,
  output logic [N_IO-1:0]      out_o
);
  for (genvar o = 0; o < N_IO; o++) begin : g_out
    logic [N_LT-1:0] col;
    for (genvar t = 0; t < N_LT; t++) begin : g_col
      assign col[t] = conn_i[t*N_IO + o];
    end
    assign out_o[o] = (|(term_i & col)) ^ inv_i[o];
  end
endmodule

// File: rtl/pla_array.sv
`timescale 1ns/1ps
module pla_array
  import pla_pkg::*;
#(
  parameter int unsigned N_IN = DEF_N_IN,
  parameter int unsigned N_IO = DEF_N_IO,
  parameter int unsigned N_LT = DEF_N_LT
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_IN-1:0] in_i,
  input  logic [N_IO-1:0] io_i,
  output logic [N_IO-1:0] io_o,
  output logic [N_IO-1:0] io_oe_o,
  input  logic            cfg_sdi_i,
  input  logic            cfg_shift_i,
  input  logic            cfg_load_i,
  input  logic            cfg_capture_i,
  input  logic            cfg_lock_i,
  input  logic            cfg_erase_i,
  output logic            cfg_sdo_o
);
  localparam int unsigned N_SIG    = N_IN + N_IO;
  localparam int unsigned N_LIT    = 2 * N_SIG;
  localparam int unsigned N_PT     = N_LT + N_IO;
  localparam int unsigned AND_W    = N_PT * N_LIT;
  localparam int unsigned OR_W     = N_LT * N_IO;
  localparam int unsigned OR_BASE  = AND_W;
  localparam int unsigned POL_BASE = AND_W + OR_W;
  localparam int unsigned CFG_W    = POL_BASE + N_IO;

  logic [CFG_W-1:0] cfg_w;
  logic             secure_w;
  logic [N_PT-1:0]  term_w;

  pla_cfg_store #(.CFG_W(CFG_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sdi_i     (cfg_sdi_i),
    .shift_i   (cfg_shift_i),
    .load_i    (cfg_load_i),
    .capture_i (cfg_capture_i),
    .lock_i    (cfg_lock_i),
    .erase_i   (cfg_erase_i),
    .cfg_o     (cfg_w),
    .secure_o  (secure_w),
    .sdo_o     (cfg_sdo_o)
  );

  pla_and_plane #(.N_SIG(N_SIG), .N_PT(N_PT)) u_and (
    .sig_i  ({io_i, in_i}),
    .mask_i (cfg_w[AND_W-1:0]),
    .term_o (term_w)
  );

  pla_or_plane #(.N_LT(N_LT), .N_IO(N_IO)) u_or (
    .term_i (term_w[N_LT-1:0]),
    .conn_i (cfg_w[OR_BASE +: OR_W]),
    .inv_i  (cfg_w[POL_BASE +: N_IO]),
    .out_o  (io_o)
  );

  // direction terms sit above the logic terms, one per pin
  assign io_oe_o = term_w[N_PT-1:N_LT];
endmodule

// File: rtl/pla_array_chk.sv
`timescale 1ns/1ps
module pla_array_chk #(
  parameter int unsigned CFG_W = 1842
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic             lock_i,
  input logic             erase_i,
  input logic [CFG_W-1:0] cfg_i,
  input logic             secure_i,
  input logic             sdo_i
);
  a_r6_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !erase_i) |=> $stable(cfg_i))
    else $error("a_r6_active_hold");

  a_r9_erase_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> (cfg_i == '0) && !secure_i)
    else $error("a_r9_erase_clears");

  a_r8_lock_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && !erase_i) |=> secure_i)
    else $error("a_r8_lock_sets");

  a_r8_secure_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (secure_i && !erase_i) |=> secure_i)
    else $error("a_r8_secure_sticky");

  a_r8_sdo_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    secure_i |-> !sdo_i)
    else $error("a_r8_sdo_silent");
endmodule

bind pla_array pla_array_chk #(.CFG_W(CFG_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .load_i   (cfg_load_i),
  .lock_i   (cfg_lock_i),
  .erase_i  (cfg_erase_i),
  .cfg_i    (cfg_w),
  .secure_i (secure_w),
  .sdo_i    (cfg_sdo_o)
);

// File: tb/tb_pla_array.sv
`timescale 1ns/1ps
module tb_pla_array;
  localparam int NI = 8, NB = 10, NL = 32;
  localparam int NS = NI + NB, NLIT = 2 * NS, NP = NL + NB;
  localparam int ORB = NP * NLIT, POLB = ORB + NL * NB, CW = POLB + NB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NI-1:0] in_v = '0;
  logic [NB-1:0] io_v = '0, q, oe;
  logic sdi = 0, shift = 0, load = 0, capture = 0, lock = 0, erase = 0, sdo;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pla_array dut (
    .clk_i(clk), .rst_ni(rst_n), .in_i(in_v), .io_i(io_v), .io_o(q), .io_oe_o(oe),
    .cfg_sdi_i(sdi), .cfg_shift_i(shift), .cfg_load_i(load), .cfg_capture_i(capture),
    .cfg_lock_i(lock), .cfg_erase_i(erase), .cfg_sdo_o(sdo));

  task automatic check(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic void ref_eval(input logic [CW-1:0] c, input logic [NI-1:0] di,
                                   input logic [NB-1:0] bi, output logic [NB-1:0] rq,
                                   output logic [NB-1:0] roe);
    logic [NP-1:0] pt;
    for (int t = 0; t < NP; t++) begin
      pt[t] = 1'b1;
      for (int s = 0; s < NS; s++) begin
        logic v;
        v = (s < NI) ? di[s] : bi[s-NI];
        if (c[t*NLIT + 2*s] && !v) pt[t] = 1'b0;
        if (c[t*NLIT + 2*s + 1] && v) pt[t] = 1'b0;
      end
    end
    for (int o = 0; o < NB; o++) begin
      logic acc;
      acc = 1'b0;
      for (int t = 0; t < NL; t++) if (c[ORB + t*NB + o] && pt[t]) acc = 1'b1;
      rq[o]  = acc ^ c[POLB + o];
      roe[o] = pt[NL + o];
    end
  endfunction

  function automatic logic [CW-1:0] rand_cfg();
    logic [CW-1:0] c;
    for (int i = 0; i < ORB; i++) c[i] = ($urandom % 18) == 0;
    for (int i = ORB; i < POLB; i++) c[i] = ($urandom % 4) == 0;
    for (int i = POLB; i < CW; i++) c[i] = $urandom % 2;
    return c;
  endfunction

  task automatic shift_in(input logic [CW-1:0] c);
    for (int i = 0; i < CW; i++) begin
      @(negedge clk); sdi = c[i]; shift = 1'b1;
    end
    @(negedge clk); shift = 1'b0; sdi = 1'b0;
  endtask

  task automatic pulse_load();
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic read_back(output logic [CW-1:0] r);
    @(negedge clk); capture = 1'b1;
    @(negedge clk); capture = 1'b0;
    for (int i = 0; i < CW; i++) begin
      r[i] = sdo; shift = 1'b1;
      @(negedge clk);
    end
    shift = 1'b0;
  endtask

  task automatic check_vec(input logic [CW-1:0] c, input int n, input string req);
    logic [NB-1:0] eq, eoe;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_v = NI'($urandom); io_v = NB'($urandom);
      #2;
      ref_eval(c, in_v, io_v, eq, eoe);
      check(req, {oe, q} === {eoe, eq}, {12'd0, oe, q}, {12'd0, eoe, eq});
    end
  endtask

  task automatic drive(input logic [NI-1:0] a, input logic [NB-1:0] b);
    @(negedge clk); in_v = a; io_v = b; #2;
  endtask

  initial begin
    #(150000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] ca, cb, cr, rb;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R10 reset state
    check("R10 io_o", q == '0, 32'(q), 0);
    check("R10 io_oe_o", oe == '1, 32'(oe), 32'h3ff);
    check("R10 sdo", sdo == 1'b0, 32'(sdo), 0);

    // directed config A
    ca = '0;
    ca[0*NLIT + 0] = 1; ca[0*NLIT + 3] = 1;           // term0 = in0 & ~in1
    ca[1*NLIT + 0] = 1; ca[1*NLIT + 1] = 1;           // term1 contradictory
    ca[ORB + 0*NB + 0] = 1; ca[ORB + 1*NB + 1] = 1;
    ca[ORB + 2*NB + 2] = 1; ca[ORB + 2*NB + 3] = 1; ca[POLB + 3] = 1;
    ca[POLB + 5] = 1;
    ca[ORB + 0*NB + 6] = 1; ca[POLB + 6] = 1;
    ca[(NL+0)*NLIT + 2*13] = 1;                         // oe0 = io5
    for (int o = 1; o < NB; o++)
      if (o != 2) begin ca[(NL+o)*NLIT + 4] = 1; ca[(NL+o)*NLIT + 5] = 1; end
    shift_in(ca);
    #2;
    check("R6 no effect before load", {oe, q} == {10'h3ff, 10'h0}, {12'd0, oe, q}, {12'd0, 10'h3ff, 10'h0});
    pulse_load();
    drive(8'b01, 10'b0);
    check("R1 term true", q[0] == 1'b1, 32'(q), 32'h1);
    check("R2 contradictory term", q[1] == 1'b0, 32'(q), 0);
    check("R2 empty term", q[2] == 1'b1, 32'(q), 32'h4);
    check("R4 invert", q[3] == 1'b0 && q[6] == 1'b0, 32'(q), 0);
    check("R3 empty OR", q[4] == 1'b0 && q[5] == 1'b1, 32'(q), 32'h20);
    check("R5 oe off", oe == 10'b0000000100, 32'(oe), 32'h4);
    drive(8'b11, 10'b0000100000);
    check("R1 complement literal", q[0] == 1'b0 && q[6] == 1'b1, 32'(q), 32'h40);
    check("R5 oe from io5", oe == 10'b0000000101, 32'(oe), 32'h5);
    check_vec(ca, 20, "R1 config A");

    // wide OR: all 32 terms into gates 0 and 1
    cb = '0;
    for (int t = 0; t < NL; t++) begin
      cb[ORB + t*NB + 0] = 1; cb[ORB + t*NB + 1] = 1;
      if (t < NL-1) begin cb[t*NLIT + 6] = 1; cb[t*NLIT + 7] = 1; end
    end
    cb[(NL-1)*NLIT + 2*17] = 1;                         // term31 = io9
    cb[POLB + 1] = 1;
    shift_in(cb); pulse_load();
    drive(8'hff, 10'h200);
    check("R3 wide OR high", q[1:0] == 2'b01, 32'(q), 32'h1);
    drive(8'hff, 10'h1ff);
    check("R3 wide OR low", q[1:0] == 2'b10, 32'(q), 32'h2);
    check_vec(cb, 10, "R3 config B");

    // random configurations
    for (int n = 0; n < 8; n++) begin
      cr = rand_cfg();
      shift_in(cr); pulse_load();
      check_vec(cr, 40, "R3 random");
      if (n == 0) begin
        read_back(rb);
        check("R7 readback", rb === cr, 32'(rb[31:0]), 32'(cr[31:0]));
        check_vec(cr, 5, "R6 readback keeps active");
      end
    end

    // security
    @(negedge clk); lock = 1'b1;
    @(negedge clk); lock = 1'b0; #2;
    check("R8 sdo silent", sdo == 1'b0, 32'(sdo), 0);
    read_back(rb);
    check("R8 readback zero", rb == '0, 32'(rb[31:0]), 0);
    check_vec(cr, 10, "R8 still active");

    // erase with concurrent load
    ca = rand_cfg();
    shift_in(ca);
    @(negedge clk); erase = 1'b1; load = 1'b1;
    @(negedge clk); erase = 1'b0; load = 1'b0; #2;
    check("R9 erase outputs", {oe, q} == {10'h3ff, 10'h0}, {12'd0, oe, q}, {12'd0, 10'h3ff, 10'h0});
    check("R9 erase sdo", sdo == 1'b0, 32'(sdo), 0);
    cb = rand_cfg();
    shift_in(cb); pulse_load();
    read_back(rb);
    check("R9 security cleared readback", rb === cb, 32'(rb[31:0]), 32'(cb[31:0]));
    check_vec(cb, 10, "R9 reload");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule